// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in front of a nonvolatile array's write path and rules on every write cycle, each one an address and a data byte offered with a valid strobe. It tracks keyed command sequences in the write stream. When protection is off, ordinary writes go through. An arming sequence of three keyed bytes, followed by one real data write, stores that write and switches protection on. While protection is on, a write is let through only if the same three-byte key has come immediately before it. A longer six-byte key switches protection off, and none of its cycles is stored.

Key cycles are consumed by the sequencer and never reach the array. A cycle that does not fit the sequence in progress aborts that sequence. The aborting cycle is then judged as if the matcher were idle: it can start a new key or be an ordinary write. All three results are registered, so each one appears in the cycle after the strobe it belongs to. Only the low 16 address bits are compared with the key addresses. When the address port is wider, the upper bits play no part in matching.

Top module: `sdp_guard`

## Requirements
- R1: Under synchronous reset, wr_permit, prot_active and seq_abort are all low, so protection starts out disabled.
- R2: With protection off and no sequence in progress, a valid write that is not a key byte raises wr_permit for exactly the one cycle after its strobe.
- R3: The arming key is 0x5555/0xAA, then 0x2AAA or 0xAAAA with 0x55, then 0x5555/0xA0. The next valid write after it is permitted, and prot_active is high from that same result cycle. Key cycles themselves are never permitted.
- R4: The arming key alone, with no write after it, leaves prot_active low.
- R5: While protection is on, a write with no key in front of it is blocked: wr_permit stays low and seq_abort stays low.
- R6: While protection is on, the arming key lets exactly one following write through, and the write after that is blocked again. prot_active stays high.
- R7: The six-cycle clearing key is 0x5555/0xAA, 0x2AAA-or-0xAAAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA-or-0xAAAA/0x55, 0x5555/0x20. prot_active falls in the result cycle of its last byte, and none of its six cycles is permitted.
- R8: For the second key byte, both 0x2AAA and 0xAAAA are accepted.
- R9: A valid cycle that breaks a sequence in progress pulses seq_abort for one cycle. That cycle is then judged from idle: 0x5555/0xAA restarts a key, and any other cycle is an ordinary write.
- R10: Cycles with wr_valid low do not advance or reset the matcher, so gaps between key bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write cycle strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| wr_permit | output | 1 | Write may reach the array (registered) |
| prot_active | output | 1 | Protection currently on |
| seq_abort | output | 1 | One-cycle pulse: a sequence was broken |

## Verification
Every result comes from a single register stage. The permit, protection and abort values for a strobe applied before edge N can be read just after edge N, and protection changes in the same cycle as the permit of the arming write. The driver applies one cycle per clock on the falling edge and queues the expected triple for that cycle. The monitor takes one queued item a quarter period after each rising edge, so every comparison falls exactly one cycle after its stimulus. Idle cycles queue their own expectations, which shows that a held key is not lost and not acted on early.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int unsigned KEY_ADDR_W = 16;
    localparam int unsigned BYTE_W     = 8;

    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_MAIN = 16'h5555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_ALT0 = 16'h2AAA;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_ALT1 = 16'hAAAA;

    localparam logic [BYTE_W-1:0] KEY_LEAD   = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_ENABLE = 8'hA0;
    localparam logic [BYTE_W-1:0] KEY_EXTEND = 8'h80;
    localparam logic [BYTE_W-1:0] KEY_CLEAR  = 8'h20;

    typedef enum logic [2:0] {
        TK_OTHER,
        TK_LEAD,
        TK_SECOND,
        TK_ENABLE,
        TK_EXTEND,
        TK_CLEAR
    } token_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SECOND,
        ST_ARMED,
        ST_EXT,
        ST_EXT_LEAD,
        ST_EXT_SECOND
    } seq_state_t;

    typedef struct packed {
        logic consume;    // cycle is a key byte, never stored
        logic abort;      // cycle broke a sequence in progress
        logic arm_write;  // cycle is the write that follows a full key
        logic clear;      // cycle completes the clearing key
    } verdict_t;

    function automatic token_t classify(input logic [KEY_ADDR_W-1:0] a,
                                        input logic [BYTE_W-1:0] d);
        logic main_hit;
        logic alt_hit;
        token_t t;
        main_hit = (a == KEY_ADDR_MAIN);
        alt_hit  = (a == KEY_ADDR_ALT0) || (a == KEY_ADDR_ALT1);
        t = TK_OTHER;
        if (main_hit && d == KEY_LEAD)        t = TK_LEAD;
        else if (alt_hit && d == KEY_SECOND)  t = TK_SECOND;
        else if (main_hit && d == KEY_ENABLE) t = TK_ENABLE;
        else if (main_hit && d == KEY_EXTEND) t = TK_EXTEND;
        else if (main_hit && d == KEY_CLEAR)  t = TK_CLEAR;
        return t;
    endfunction

endpackage

// File: rtl/sdp_classify.sv
module sdp_classify
    import sdp_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] data_i,
    output token_t            token_o
);
    logic [KEY_ADDR_W-1:0] low_addr;

    generate
        if (ADDR_W >= KEY_ADDR_W) begin : g_slice
            assign low_addr = addr_i[KEY_ADDR_W-1:0];
        end else begin : g_pad
            assign low_addr = {{(KEY_ADDR_W-ADDR_W){1'b0}}, addr_i};
        end
    endgenerate

    assign token_o = classify(low_addr, data_i);
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
    import sdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  token_t     token_i,
    output verdict_t   verdict_o,
    output seq_state_t state_o
);
    seq_state_t state_q, state_d;
    seq_state_t idle_next;
    logic       idle_consume;

    // outcome of the cycle if the matcher were idle
    always_comb begin
        if (token_i == TK_LEAD) begin
            idle_next    = ST_LEAD;
            idle_consume = 1'b1;
        end else begin
            idle_next    = ST_IDLE;
            idle_consume = 1'b0;
        end
    end

    always_comb begin
        state_d   = state_q;
        verdict_o = '0;
        if (valid_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d           = idle_next;
                    verdict_o.consume = idle_consume;
                end
                ST_LEAD, ST_EXT_LEAD: begin
                    if (token_i == TK_SECOND) begin
                        state_d           = (state_q == ST_LEAD) ? ST_SECOND : ST_EXT_SECOND;
                        verdict_o.consume = 1'b1;
                    end else begin
                        state_d           = idle_next;
                        verdict_o.consume = idle_consume;
                        verdict_o.abort   = 1'b1;
                    end
                end
                ST_SECOND: begin
                    if (token_i == TK_ENABLE) begin
                        state_d           = ST_ARMED;
                        verdict_o.consume = 1'b1;
                    end else if (token_i == TK_EXTEND) begin
                        state_d           = ST_EXT;
                        verdict_o.consume = 1'b1;
                    end else begin
                        state_d           = idle_next;
                        verdict_o.consume = idle_consume;
                        verdict_o.abort   = 1'b1;
                    end
                end
                ST_ARMED: begin
                    state_d             = ST_IDLE;
                    verdict_o.arm_write = 1'b1;
                end
                ST_EXT: begin
                    if (token_i == TK_LEAD) begin
                        state_d           = ST_EXT_LEAD;
                        verdict_o.consume = 1'b1;
                    end else begin
                        state_d           = idle_next;
                        verdict_o.consume = idle_consume;
                        verdict_o.abort   = 1'b1;
                    end
                end
                ST_EXT_SECOND: begin
                    if (token_i == TK_CLEAR) begin
                        state_d           = ST_IDLE;
                        verdict_o.consume = 1'b1;
                        verdict_o.clear   = 1'b1;
                    end else begin
                        state_d           = idle_next;
                        verdict_o.consume = idle_consume;
                        verdict_o.abort   = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    // R6: the armed state passes one write and then returns to idle
    p_armed_single_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && valid_i) |=> (state_q == ST_IDLE));

    // R9: an abort only comes from a sequence already under way
    p_abort_busy_r9: assert property (@(posedge clk) disable iff (rst)
        verdict_o.abort |-> (state_q != ST_IDLE && state_q != ST_ARMED));

    // R10: a cycle without a strobe leaves the matcher where it was
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(state_q));
endmodule

// File: rtl/sdp_gate.sv
module sdp_gate
    import sdp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid_i,
    input  verdict_t verdict_i,
    output logic     permit_o,
    output logic     prot_o,
    output logic     abort_o
);
    logic permit_q, prot_q, abort_q;
    logic permit_d, prot_d;

    always_comb begin
        permit_d = valid_i && (verdict_i.arm_write || (!verdict_i.consume && !prot_q));
        if (verdict_i.arm_write)  prot_d = 1'b1;
        else if (verdict_i.clear) prot_d = 1'b0;
        else                      prot_d = prot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            permit_q <= 1'b0;
            prot_q   <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            permit_q <= permit_d;
            prot_q   <= prot_d;
            abort_q  <= verdict_i.abort;
        end
    end

    assign permit_o = permit_q;
    assign prot_o   = prot_q;
    assign abort_o  = abort_q;

    // R5: while protected, only the write after a full key is let through
    p_blocked_when_protected_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && prot_q && !verdict_i.arm_write) |=> !permit_q);

    // R3: a consumed key byte is never stored
    p_key_not_stored_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && verdict_i.consume) |=> !permit_q);
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
    import sdp_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_permit,
    output logic              prot_active,
    output logic              seq_abort
);
    token_t     token;
    verdict_t   verdict;
    seq_state_t seq_state;

    sdp_classify #(.ADDR_W(ADDR_W)) u_classify (
        .addr_i  (wr_addr),
        .data_i  (wr_data),
        .token_o (token)
    );

    sdp_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (wr_valid),
        .token_i   (token),
        .verdict_o (verdict),
        .state_o   (seq_state)
    );

    sdp_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (wr_valid),
        .verdict_i (verdict),
        .permit_o  (wr_permit),
        .prot_o    (prot_active),
        .abort_o   (seq_abort)
    );

    // R1: reset clears every result
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!wr_permit && !prot_active && !seq_abort));

    // R2: a permit always answers a strobe one cycle earlier
    p_permit_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> $past(wr_valid));

    // R3: protection switches on together with the stored arming write
    p_prot_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_active) |-> wr_permit);

    // R7: the clearing byte itself is not stored
    p_clear_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_active) |-> !wr_permit);

    // R9: an abort pulse always answers a strobe
    p_abort_after_valid_r9: assert property (@(posedge clk) disable iff (rst)
        seq_abort |-> $past(wr_valid) && $past(seq_state) != ST_IDLE);
endmodule

// File: tb/sdp_guard_bench.sv
module sdp_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic  permit;
        logic  prot;
        logic  abort;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              wr_permit, prot_active, seq_abort;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t pending[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdp_guard #(.ADDR_W(ADDR_W)) u_sdp_guard (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_permit   (wr_permit),
        .prot_active (prot_active),
        .seq_abort   (seq_abort)
    );

    // driver: one cycle per call, expected result queued for the next edge
    task automatic drive(input logic v, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input logic ep, input logic epr, input logic eab, input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = v;
        wr_addr  = a;
        wr_data  = d;
        e.permit = ep;
        e.prot   = epr;
        e.abort  = eab;
        e.tag    = tag;
        pending.push_back(e);
    endtask

    // monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (pending.size() > 0) begin
            exp_t e;
            e = pending.pop_front();
            n_checks++;
            if (wr_permit !== e.permit || prot_active !== e.prot || seq_abort !== e.abort) begin
                n_fail++;
                $display("FAIL %s: permit/prot/abort got %b%b%b expected %b%b%b",
                         e.tag, wr_permit, prot_active, seq_abort, e.permit, e.prot, e.abort);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "R1 reset state");
        // R2: plain write while unprotected
        drive(1, 16'h0100, 8'h3C, 1, 0, 0, "R2 open write");
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "R2 permit one cycle");
        // R3/R4/R10: arming key with gaps, key bytes not stored
        drive(1, 16'h5555, 8'hAA, 0, 0, 0, "R3 key byte 1 not stored");
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "R10 gap");
        drive(1, 16'h2AAA, 8'h55, 0, 0, 0, "R3 key byte 2 not stored");
        drive(1, 16'h5555, 8'hA0, 0, 0, 0, "R3 key byte 3 not stored");
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "R4 key alone leaves prot off");
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "R4 key alone leaves prot off");
        drive(1, 16'h1234, 8'h77, 1, 1, 0, "R3 arming write stored, prot on");
        // R5: unkeyed write blocked
        drive(1, 16'h0200, 8'h11, 0, 1, 0, "R5 unkeyed write blocked");
        // R6/R8: keyed write with alternate second address
        drive(1, 16'h5555, 8'hAA, 0, 1, 0, "R6 key 1");
        drive(1, 16'hAAAA, 8'h55, 0, 1, 0, "R8 alt address accepted");
        drive(1, 16'h5555, 8'hA0, 0, 1, 0, "R6 key 3");
        drive(1, 16'h0300, 8'h42, 1, 1, 0, "R6 keyed write passes");
        drive(1, 16'h0301, 8'h43, 0, 1, 0, "R6 second write blocked");
        // R9: abort into ordinary (blocked) write
        drive(1, 16'h5555, 8'hAA, 0, 1, 0, "R9 start");
        drive(1, 16'h0400, 8'h12, 0, 1, 1, "R9 break, blocked write");
        // R9: abort that restarts a key
        drive(1, 16'h5555, 8'hAA, 0, 1, 0, "R9 start again");
        drive(1, 16'h5555, 8'hAA, 0, 1, 1, "R9 break restarts key");
        drive(1, 16'h2AAA, 8'h55, 0, 1, 0, "R9 restarted key 2");
        drive(1, 16'h5555, 8'hA0, 0, 1, 0, "R9 restarted key 3");
        drive(1, 16'h0410, 8'h5A, 1, 1, 0, "R9 restarted key lets write through");
        // R7: clearing key
        drive(1, 16'h5555, 8'hAA, 0, 1, 0, "R7 clear 1");
        drive(1, 16'h2AAA, 8'h55, 0, 1, 0, "R7 clear 2");
        drive(1, 16'h5555, 8'h80, 0, 1, 0, "R7 clear 3");
        drive(1, 16'h5555, 8'hAA, 0, 1, 0, "R7 clear 4");
        drive(1, 16'hAAAA, 8'h55, 0, 1, 0, "R7 clear 5");
        drive(1, 16'h5555, 8'h20, 0, 0, 0, "R7 clear 6 drops prot, not stored");
        drive(1, 16'h0500, 8'h66, 1, 0, 0, "R7 open write after clear");
        // R9: abort into ordinary permitted write
        drive(1, 16'h5555, 8'hAA, 0, 0, 0, "R9 start open");
        drive(1, 16'h0600, 8'h99, 1, 0, 1, "R9 break, write stored");
        // R9: clearing key broken mid-way while unprotected
        drive(1, 16'h5555, 8'hAA, 0, 0, 0, "R9 ext 1");
        drive(1, 16'h2AAA, 8'h55, 0, 0, 0, "R9 ext 2");
        drive(1, 16'h5555, 8'h80, 0, 0, 0, "R9 ext 3");
        drive(1, 16'h0700, 8'h01, 1, 0, 1, "R9 ext break");
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "R9 abort is one pulse");
        drive(0, 16'h0000, 8'h00, 0, 0, 0, "idle drain");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule